// File: doc/BRIEF.md
# Stereo Soft Mute Ramp

This block fades a stereo stream of 20-bit two's complement samples to silence and back. A plain mute request input sets the direction of travel. While the request is high, the shared gain steps one notch toward zero on each accepted left/right frame. While the request is low, it steps one notch back toward unity. A full ramp in either direction takes `RAMP_LEN` frames. A release that arrives partway through a fade turns the ramp around at the gain it has reached. The ramp does not restart from either end.

Frames enter through a valid/ready input port, one left/right pair per transfer. Each accepted transfer is the frame strobe. The scaled pair is offered on a valid/ready output port one clock after acceptance. The input is ready whenever the output register is empty or is being drained in the same cycle. A frame held back by back-pressure therefore waits at the input and does not move the gain. While the output is stalled, the offered pair stays unchanged. A status pin reports when the fade has reached silence and the request is still high.

Top module: `soft_mute_ramp`

## Requirements
- R1: After a synchronous reset the gain is unity (`RAMP_LEN`), `m_valid` is low, `s_ready` is high and `muted` is low.
- R2: Each accepted frame while `mute_req` is high lowers the gain by one step until it reaches 0. Starting from unity, exactly `RAMP_LEN` accepted frames reach 0.
- R3: Each accepted frame while `mute_req` is low raises the gain by one step until it reaches unity. Starting from 0, exactly `RAMP_LEN` accepted frames reach unity.
- R4: A change of `mute_req` in the middle of a ramp reverses the ramp from the gain already reached. After k falling frames from unity, k rising frames restore unity.
- R5: The gain changes only on an accepted input frame. Both channels of a frame are scaled with the same gain, which is the gain held before that frame's step.
- R6: Each output sample equals floor((sample*gain + RAMP_LEN/2) / RAMP_LEN), which is round to nearest with halves rounded upward. The result is clamped to the 20-bit signed range.
- R7: A frame accepted at gain 0 produces exactly 0 on both channels.
- R8: `muted` is high exactly when the gain is 0 and `mute_req` is high.
- R9: A frame accepted on a rising edge appears on `m_left`/`m_right` with `m_valid` high after that edge. `s_ready` is high exactly when `m_valid` is low or `m_ready` is high. While `m_valid` is high and `m_ready` is low, `m_valid` and the output data hold.
- R10: A frame accepted at unity gain leaves the block unchanged, including the values 0x7FFFF and 0x80000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| mute_req | input | 1 | High: fade toward silence; low: fade toward unity |
| s_valid | input | 1 | Input frame present |
| s_ready | output | 1 | Block can take an input frame this cycle |
| s_left | input | DATA_W | Left input sample, two's complement |
| s_right | input | DATA_W | Right input sample, two's complement |
| m_valid | output | 1 | Scaled frame present |
| m_ready | input | 1 | Downstream takes the scaled frame |
| m_left | output | DATA_W | Left scaled sample |
| m_right | output | DATA_W | Right scaled sample |
| muted | output | 1 | Gain is 0 and mute is requested |

## Verification
The bench builds the block with `RAMP_LEN` set to 32 and the default 20-bit samples. A full fade then costs only 32 frames, so complete descents, complete ascents, reversals at several depths and long stalls all fit in a short run. Full-scale positive and negative samples are still scaled at every gain step. The rounding and clamping paths are therefore exercised at the same relative positions that the default 1024-step ramp uses.

// File: rtl/smr_pkg.sv
package smr_pkg;

  // Ramp position, derived from gain and request direction.
  typedef enum logic [1:0] {
    ST_UNITY  = 2'd0,
    ST_FALL   = 2'd1,
    ST_SILENT = 2'd2,
    ST_RISE   = 2'd3
  } ramp_state_e;

endpackage

// File: rtl/smr_gain_ctrl.sv
module smr_gain_ctrl
  import smr_pkg::*;
#(
  parameter int RAMP_LEN = 1024,
  parameter int GAIN_W   = $clog2(RAMP_LEN) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mute_req,
  input  logic              step_en,
  output logic [GAIN_W-1:0] gain,
  output ramp_state_e       state
);

  localparam logic [GAIN_W-1:0] UNITY = GAIN_W'(RAMP_LEN);

  logic [GAIN_W-1:0] gain_q, gain_d;
  ramp_state_e       state_q, state_d;

  always_comb begin
    gain_d = gain_q;
    if (step_en) begin
      if (mute_req && gain_q != '0)
        gain_d = gain_q - 1'b1;
      else if (!mute_req && gain_q != UNITY)
        gain_d = gain_q + 1'b1;
    end
  end

  always_comb begin
    if (gain_d == '0)
      state_d = ST_SILENT;
    else if (gain_d == UNITY)
      state_d = ST_UNITY;
    else if (mute_req)
      state_d = ST_FALL;
    else
      state_d = ST_RISE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gain_q  <= UNITY;
      state_q <= ST_UNITY;
    end else begin
      gain_q  <= gain_d;
      state_q <= state_d;
    end
  end

  assign gain  = gain_q;
  assign state = state_q;

endmodule

// File: rtl/smr_scaler.sv
module smr_scaler #(
  parameter int DATA_W   = 20,
  parameter int RAMP_LEN = 1024,
  parameter int GAIN_W   = $clog2(RAMP_LEN) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] sample,
  input  logic [GAIN_W-1:0] gain,
  output logic [DATA_W-1:0] scaled
);

  localparam int SH = $clog2(RAMP_LEN);
  localparam int PW = DATA_W + GAIN_W + 2;
  localparam logic signed [PW-1:0] HALF = PW'(1) << (SH - 1);
  localparam logic signed [PW-1:0] MAXV = (PW'(1) << (DATA_W - 1)) - PW'(1);
  localparam logic signed [PW-1:0] MINV = -(PW'(1) << (DATA_W - 1));

  logic signed [PW-1:0] a_ext, g_ext, prod, rnd, shr;
  logic [DATA_W-1:0]    sat;
  logic [DATA_W-1:0]    scaled_q;

  always_comb begin
    a_ext = {{(PW-DATA_W){sample[DATA_W-1]}}, sample};
    g_ext = {{(PW-GAIN_W){1'b0}}, gain};
    prod  = a_ext * g_ext;
    rnd   = prod + HALF;
    shr   = rnd >>> SH;
    if (shr > MAXV)
      sat = MAXV[DATA_W-1:0];
    else if (shr < MINV)
      sat = MINV[DATA_W-1:0];
    else
      sat = shr[DATA_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)
      scaled_q <= '0;
    else if (load)
      scaled_q <= sat;
  end

  assign scaled = scaled_q;

endmodule

// File: rtl/soft_mute_ramp.sv
module soft_mute_ramp
  import smr_pkg::*;
#(
  parameter int DATA_W   = 20,
  parameter int RAMP_LEN = 1024,
  parameter int GAIN_W   = $clog2(RAMP_LEN) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mute_req,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_left,
  input  logic [DATA_W-1:0] s_right,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [DATA_W-1:0] m_left,
  output logic [DATA_W-1:0] m_right,
  output logic              muted
);

  localparam int NCH = 2;

  logic              accept;
  logic              out_v_q;
  logic [GAIN_W-1:0] gain_w;
  ramp_state_e       state_w;
  logic [DATA_W-1:0] ch_in  [NCH];
  logic [DATA_W-1:0] ch_out [NCH];

  assign s_ready = !out_v_q || m_ready;
  assign accept  = s_valid && s_ready;

  smr_gain_ctrl #(
    .RAMP_LEN (RAMP_LEN),
    .GAIN_W   (GAIN_W)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .mute_req (mute_req),
    .step_en  (accept),
    .gain     (gain_w),
    .state    (state_w)
  );

  assign ch_in[0] = s_left;
  assign ch_in[1] = s_right;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    smr_scaler #(
      .DATA_W   (DATA_W),
      .RAMP_LEN (RAMP_LEN),
      .GAIN_W   (GAIN_W)
    ) u_scale (
      .clk    (clk),
      .rst    (rst),
      .load   (accept),
      .sample (ch_in[ch]),
      .gain   (gain_w),
      .scaled (ch_out[ch])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)
      out_v_q <= 1'b0;
    else if (accept)
      out_v_q <= 1'b1;
    else if (m_ready)
      out_v_q <= 1'b0;
  end

  assign m_valid = out_v_q;
  assign m_left  = ch_out[0];
  assign m_right = ch_out[1];
  assign muted   = (state_w == ST_SILENT) && mute_req;

endmodule

// File: rtl/smr_checker.sv
module smr_checker #(
  parameter int DATA_W   = 20,
  parameter int RAMP_LEN = 1024,
  parameter int GAIN_W   = $clog2(RAMP_LEN) + 1
) (
  input logic              clk,
  input logic              rst,
  input logic              mute_req,
  input logic              s_valid,
  input logic              s_ready,
  input logic              m_valid,
  input logic              m_ready,
  input logic [DATA_W-1:0] m_left,
  input logic [DATA_W-1:0] m_right,
  input logic              muted,
  input logic [GAIN_W-1:0] gain
);

  localparam logic [GAIN_W-1:0] UNITY = GAIN_W'(RAMP_LEN);

  AST_GAIN_RANGE: assert property (@(posedge clk) disable iff (rst)
    gain <= UNITY);  // R2

  AST_FALL_STEP: assert property (@(posedge clk) disable iff (rst)
    s_valid && s_ready && mute_req && gain != '0 |=> gain == $past(gain) - 1'b1);  // R2

  AST_RISE_STEP: assert property (@(posedge clk) disable iff (rst)
    s_valid && s_ready && !mute_req && gain != UNITY |=> gain == $past(gain) + 1'b1);  // R3

  AST_GAIN_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(s_valid && s_ready) |=> $stable(gain));  // R5

  AST_ZERO_OUT: assert property (@(posedge clk) disable iff (rst)
    s_valid && s_ready && muted |=> m_valid && m_left == '0 && m_right == '0);  // R7

  AST_MUTED_REQ: assert property (@(posedge clk) disable iff (rst)
    muted |-> mute_req && gain == '0);  // R8

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    m_valid && !m_ready |=> m_valid && $stable(m_left) && $stable(m_right));  // R9

  AST_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    !s_ready |-> m_valid);  // R9

endmodule

bind soft_mute_ramp smr_checker #(
  .DATA_W   (DATA_W),
  .RAMP_LEN (RAMP_LEN),
  .GAIN_W   (GAIN_W)
) u_smr_chk (
  .clk      (clk),
  .rst      (rst),
  .mute_req (mute_req),
  .s_valid  (s_valid),
  .s_ready  (s_ready),
  .m_valid  (m_valid),
  .m_ready  (m_ready),
  .m_left   (m_left),
  .m_right  (m_right),
  .muted    (muted),
  .gain     (gain_w)
);

// File: tb/test_soft_mute_ramp.sv
module test_soft_mute_ramp;

  localparam int CLK_PERIOD = 10;
  localparam int DW   = 20;
  localparam int RL   = 32;
  localparam int SH   = $clog2(RL);
  localparam int GW   = SH + 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          mute_req = 1'b0;
  logic          s_valid = 1'b0;
  logic          s_ready;
  logic [DW-1:0] s_left = '0;
  logic [DW-1:0] s_right = '0;
  logic          m_valid;
  logic          m_ready = 1'b1;
  logic [DW-1:0] m_left;
  logic [DW-1:0] m_right;
  logic          muted;

  int  checks = 0;
  int  errors = 0;
  bit  bp_on  = 1'b0;

  // reference model state
  int     mdl_gain = RL;
  bit     mdl_v    = 1'b0;
  longint mdl_l    = 0;
  longint mdl_r    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  soft_mute_ramp #(.DATA_W(DW), .RAMP_LEN(RL)) i_soft_mute_ramp (
    .clk(clk), .rst(rst), .mute_req(mute_req),
    .s_valid(s_valid), .s_ready(s_ready), .s_left(s_left), .s_right(s_right),
    .m_valid(m_valid), .m_ready(m_ready), .m_left(m_left), .m_right(m_right),
    .muted(muted)
  );

  function automatic longint sx(input logic [DW-1:0] v);
    return longint'($signed(v));
  endfunction

  function automatic longint scale(input longint s, input int g);
    longint p;
    p = (s * g + (RL / 2)) >>> SH;
    if (p > (2**(DW-1)) - 1) p = (2**(DW-1)) - 1;
    if (p < -(2**(DW-1)))    p = -(2**(DW-1));
    return p;
  endfunction

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference, advanced on each rising edge
  always @(posedge clk) begin
    bit rdy;
    if (rst) begin
      mdl_gain = RL;
      mdl_v    = 1'b0;
    end else begin
      rdy = !mdl_v || m_ready;
      if (mdl_v && m_ready) mdl_v = 1'b0;
      if (s_valid && rdy) begin
        mdl_l = scale(sx(s_left), mdl_gain);
        mdl_r = scale(sx(s_right), mdl_gain);
        mdl_v = 1'b1;
        if (mute_req && mdl_gain > 0)       mdl_gain--;
        else if (!mute_req && mdl_gain < RL) mdl_gain++;
      end
    end
  end

  // cycle compare away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      check("R9 m_valid", m_valid, mdl_v);
      check("R9 s_ready", s_ready, !mdl_v || m_ready);
      check("R8 muted", muted, (mdl_gain == 0) && mute_req);
      if (mdl_v) begin
        check("R6 left", sx(m_left), mdl_l);
        check("R6 right", sx(m_right), mdl_r);
      end
    end
  end

  // downstream readiness
  always @(posedge clk) begin
    #1;
    m_ready <= bp_on ? ($urandom_range(0, 3) != 0) : 1'b1;
  end

  task automatic send(input logic [DW-1:0] l, input logic [DW-1:0] r);
    @(posedge clk); #2;
    s_valid = 1'b1; s_left = l; s_right = r;
    forever begin
      @(negedge clk);
      if (s_ready) break;
    end
    @(posedge clk); #2;
    s_valid = 1'b0;
  endtask

  task automatic send_n(input int n);
    for (int i = 0; i < n; i++)
      send(DW'($urandom), DW'($urandom));
  endtask

  // send a frame, then read it at the following falling edge
  task automatic probe(input logic [DW-1:0] l, input logic [DW-1:0] r,
                       input string tag, input longint el, input longint er);
    send(l, r);
    @(negedge clk);
    check(tag, m_valid, 1);
    check(tag, sx(m_left), el);
    check(tag, sx(m_right), er);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    errors++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 m_valid", m_valid, 0);
    check("R1 s_ready", s_ready, 1);
    check("R1 muted", muted, 0);

    // R10 unity passes data unchanged, extremes included
    probe(20'h7FFFF, 20'h80000, "R10 extremes", 524287, -524288);
    probe(20'h00001, 20'hFFFFF, "R10 small", 1, -1);

    // R5 stalls with mute high: no frames, gain must not move
    mute_req = 1'b1;
    repeat (100) @(posedge clk);
    @(negedge clk);
    check("R5 no step muted", muted, 0);
    probe(20'h12345, 20'h80000, "R5 unity kept", 74565, -524288);

    // R2 full descent: one frame already taken above, RL-2 more
    send_n(RL - 2);
    @(negedge clk);
    check("R2 one step left", muted, 0);
    probe(20'h40000, 20'hC0000, "R2 last step gain 1", scale(262144, 1), scale(-262144, 1));
    @(negedge clk);
    check("R2 silent after RL", muted, 1);

    // R7 exact zero at gain 0
    probe(20'h7FFFF, 20'h80000, "R7 zero", 0, 0);

    // R8 status drops with the request
    @(posedge clk); #2 mute_req = 1'b0;
    @(negedge clk);
    check("R8 release clears", muted, 0);

    // R3 full ascent: RL-1 frames leave gain RL-1
    send_n(RL - 1);
    probe(20'h40000, 20'h7FFFF, "R3 gain RL-1",
          scale(262144, RL - 1), scale(524287, RL - 1));
    probe(20'h7FFFF, 20'h80000, "R3 unity", 524287, -524288);

    // R4 reversal mid-ramp
    mute_req = 1'b1;
    send_n(10);
    mute_req = 1'b0;
    probe(20'h40000, 20'h40000, "R4 turn gain", scale(262144, RL - 10), scale(262144, RL - 10));
    send_n(9);
    probe(20'h54321, 20'hABCDE, "R4 back to unity", sx(20'h54321), sx(20'hABCDE));

    // R6 rounding: half rounds up, negative half toward +inf
    mute_req = 1'b1;
    send_n(RL - 1);
    probe(20'h00010, 20'hFFFF0, "R6 half round", 1, 0);
    probe(20'h00001, 20'hFFFFF, "R6 gain0", 0, 0);

    // R9 back-pressure with mixed traffic and direction changes
    bp_on = 1'b1;
    for (int k = 0; k < 12; k++) begin
      mute_req = k[0];
      send_n(20);
      repeat ($urandom_range(0, 5)) @(posedge clk);
    end
    bp_on = 1'b0;
    repeat (5) @(posedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule